// File: doc/BRIEF.md
# Loss-of-Signal Alarm Qualifier

This block turns a raw "signal absent" flag from a line receiver's amplitude detector into a declared loss-of-signal alarm. The flag arrives asynchronously, so it is first brought into the reference clock domain. A run timer then counts reference clock cycles while the flag stays high. The alarm is declared only when the run reaches the window picked by a timer-mode select. One window is in milliseconds, for slow-declare line standards. The other is a short count of bit periods. The reference clock runs at the line bit rate, so one reference cycle is one bit period. The amplitude of the signal before the loss has no effect, because only the duration of the flag is counted.

The declared alarm drives two more things. The first is a status bit that latches on each new alarm and clears when software strobes a read. The second is a single-cycle interrupt pulse on each rising edge of the alarm. Three mask inputs gate the pulse: one for this alarm, one for the channel and one global. Any one of them set suppresses it. The block has no data stream, so every pin is a plain level or strobe with no valid/ready handshake.

Top module: `los_alarm_qualifier`

## Requirements
- R1: While and right after reset (rst_ni low), alarm_o, status_o and irq_o are all 0.
- R2: With timer_mode_i = 0 (millisecond window), a sig_absent_i held high makes alarm_o rise exactly MS_WINDOW+1 clock edges after the first edge that samples it high. MS_WINDOW is REF_CLK_HZ*HOLD_TENTHS_MS/10000, which is 3072 at the defaults (1.5 ms), inside the 1 ms to 2.6 ms limit.
- R3: With timer_mode_i = 1 (bit-period window), alarm_o rises exactly BIT_WINDOW+1 edges after the first edge that samples sig_absent_i high. BIT_WINDOW is 32 by default, inside the 10 to 255 bit-period limit.
- R4: If sig_absent_i falls before the alarm is declared, the run timer restarts. A later loss then needs the full window again, counted from its own first sampling edge.
- R5: alarm_o stays high while sig_absent_i stays high. After the first edge that samples sig_absent_i low, alarm_o is still high for one more edge and is low after the second edge.
- R6: status_o goes to 1 one edge after alarm_o rises. It then stays 1 until a read, including after alarm_o has cleared.
- R7: A status_rd_i high at an edge with no new alarm rise clears status_o at that edge. status_o stays 0 even while alarm_o is still high, until the next rise.
- R8: A status_rd_i high at the same edge where a new alarm rise is recorded leaves status_o at 1.
- R9: With all three masks at 0, irq_o is high for exactly one cycle, starting one edge after alarm_o rises.
- R10: If any of mask_alarm_i, mask_chan_i or mask_glob_i is 1, the alarm rise raises no irq_o pulse, but status_o still sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference (transmit) clock at the line bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sig_absent_i | input | 1 | Raw, asynchronous amplitude-loss flag from the detector |
| timer_mode_i | input | 1 | 0: millisecond window, 1: bit-period window |
| mask_alarm_i | input | 1 | Per-alarm interrupt mask |
| mask_chan_i | input | 1 | Per-channel interrupt mask |
| mask_glob_i | input | 1 | Global interrupt mask |
| status_rd_i | input | 1 | One-cycle status read strobe (clears the status) |
| alarm_o | output | 1 | Live declared loss-of-signal alarm |
| status_o | output | 1 | Latched alarm status, clears on read |
| irq_o | output | 1 | One-cycle interrupt pulse on each alarm rise |

## Verification
If sig_absent_i is first sampled high at edge k, alarm_o is due high after edge k+WINDOW+1. status_o and irq_o follow one edge later, and irq_o drops again the edge after that. After a falling flag is first sampled at edge j, alarm_o is due low after edge j+2. A read strobe sampled at edge r takes effect on status_o right after edge r. The driver records the edge number of each stimulus and pushes every expected value into a queue, tagged with the exact edge after which it is due. The monitor samples on the falling clock edge and compares each item in the cycle it names, so an output that is one cycle early or late counts as a mismatch.

// File: rtl/los_pkg.sv
package los_pkg;

  typedef enum logic {
    TMR_MS   = 1'b0,
    TMR_BITS = 1'b1
  } tmr_mode_e;

  // Reference cycles in a span given in tenths of a millisecond.
  function automatic int unsigned tenths_ms_to_ticks(int unsigned hz, int unsigned tenths);
    return (hz * tenths) / 10000;
  endfunction

endpackage

// File: rtl/los_sync.sv
module los_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/los_window_timer.sv
module los_window_timer
  import los_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int MS_WINDOW  = 3072,
  parameter int BIT_WINDOW = 32,
  parameter int MS_MIN     = 2048,
  parameter int BIT_MIN    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loss_i,
  input  logic mode_i,
  output logic alarm_o,
  output logic rise_o
);

  localparam logic [CNT_W-1:0] MS_LIM    = CNT_W'(MS_WINDOW);
  localparam logic [CNT_W-1:0] BIT_LIM   = CNT_W'(BIT_WINDOW);
  localparam logic [CNT_W-1:0] MS_FLOOR  = CNT_W'(MS_MIN - 1);
  localparam logic [CNT_W-1:0] BIT_FLOOR = CNT_W'(BIT_MIN - 1);

  tmr_mode_e         mode;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q;
  logic              alarm_q;
  logic              rise_q;
  logic              declare;

  assign mode = tmr_mode_e'(mode_i);

  always_comb begin
    limit = (mode == TMR_BITS) ? BIT_LIM : MS_LIM;
  end

  // Declaration point: the run has reached the window for the current mode.
  assign declare = loss_i && !alarm_q && (cnt_q >= limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= declare;
      if (!loss_i) begin
        cnt_q   <= '0;
        alarm_q <= 1'b0;
      end else begin
        if (!alarm_q) cnt_q <= cnt_q + 1'b1;
        if (declare)  alarm_q <= 1'b1;
      end
    end
  end

  assign alarm_o = alarm_q;
  assign rise_o  = rise_q;

  AST_ALARM_NEEDS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_q |-> $past(loss_i)); // R5
  AST_NO_EARLY_DECLARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> ($past(cnt_q) >= (($past(mode) == TMR_BITS) ? BIT_FLOOR : MS_FLOOR))); // R2, R3
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |=> !rise_q); // R9
  AST_RISE_MARKS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (alarm_q && !$past(alarm_q))); // R6

endmodule

// File: rtl/los_event_latch.sv
module los_event_latch #(
  parameter int N_MASK = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              rd_i,
  input  logic [N_MASK-1:0] mask_i,
  output logic              status_o,
  output logic              irq_o
);

  logic status_q;
  logic irq_q;
  logic blocked;

  assign blocked = |mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // A new rise wins over a read in the same cycle.
      if (rise_i)    status_q <= 1'b1;
      else if (rd_i) status_q <= 1'b0;
      irq_q <= rise_i && !blocked;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  AST_STATUS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> status_q); // R8
  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !rd_i) |=> status_q); // R6
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rise_i) |=> !status_q); // R7
  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> !irq_q); // R10
  AST_IRQ_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(rise_i)); // R9

endmodule

// File: rtl/los_alarm_qualifier.sv
module los_alarm_qualifier
  import los_pkg::*;
#(
  parameter int REF_CLK_HZ     = 2048000,
  parameter int HOLD_TENTHS_MS = 15,
  parameter int BIT_WINDOW     = 32,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_absent_i,
  input  logic timer_mode_i,
  input  logic mask_alarm_i,
  input  logic mask_chan_i,
  input  logic mask_glob_i,
  input  logic status_rd_i,
  output logic alarm_o,
  output logic status_o,
  output logic irq_o
);

  localparam int MS_WINDOW  = int'(tenths_ms_to_ticks(REF_CLK_HZ, HOLD_TENTHS_MS));
  localparam int MS_MIN     = int'(tenths_ms_to_ticks(REF_CLK_HZ, 10));
  localparam int BIT_MIN    = 10;
  localparam int MAX_WINDOW = (MS_WINDOW > BIT_WINDOW) ? MS_WINDOW : BIT_WINDOW;
  localparam int CNT_W      = $clog2(MAX_WINDOW + 1);
  localparam int N_MASK     = 3;

  logic              loss_sync;
  logic              rise;
  logic [N_MASK-1:0] masks;

  assign masks = {mask_glob_i, mask_chan_i, mask_alarm_i};

  los_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sig_absent_i),
    .sync_o  (loss_sync)
  );

  los_window_timer #(
    .CNT_W      (CNT_W),
    .MS_WINDOW  (MS_WINDOW),
    .BIT_WINDOW (BIT_WINDOW),
    .MS_MIN     (MS_MIN),
    .BIT_MIN    (BIT_MIN)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .loss_i  (loss_sync),
    .mode_i  (timer_mode_i),
    .alarm_o (alarm_o),
    .rise_o  (rise)
  );

  los_event_latch #(
    .N_MASK (N_MASK)
  ) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .rd_i     (status_rd_i),
    .mask_i   (masks),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  AST_IRQ_AFTER_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(alarm_o) && !$past(alarm_o, 2)); // R9

endmodule

// File: tb/sim_los_alarm_qualifier.sv
`timescale 1ns/1ps
module sim_los_alarm_qualifier;

  localparam int BITW = 32;
  localparam int MSW  = 2048000 * 15 / 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig = 1'b0, mode = 1'b0, m_al = 1'b0, m_ch = 1'b0, m_gl = 1'b0, rd = 1'b0;
  logic alarm, status, irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  los_alarm_qualifier u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sig_absent_i (sig),
    .timer_mode_i (mode),
    .mask_alarm_i (m_al),
    .mask_chan_i  (m_ch),
    .mask_glob_i  (m_gl),
    .status_rd_i  (rd),
    .alarm_o      (alarm),
    .status_o     (status),
    .irq_o        (irq)
  );

  // sig: 0 alarm_o, 1 status_o, 2 irq_o
  task automatic expect_at(input int c, input int s, input bit v, input string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_status();
    @(negedge clk);
    rd = 1'b1;
    expect_at(cyc + 1, 1, 1'b0, "R7");
    @(negedge clk);
    rd = 1'b0;
    drain();
  endtask

  // Monitor: compares each expected item after the edge it names.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      bit act;
      e = q.pop_front();
      act = (e.sig == 0) ? alarm : (e.sig == 1) ? status : irq;
      checks++;
      if (e.cyc != cyc || act != e.val) begin
        fails++;
        $display("FAIL %s: signal %0d at cycle %0d actual=%0b expected=%0b (due cycle %0d)",
                 e.req, e.sig, cyc, act, e.val, e.cyc);
      end
    end
  end

  task automatic masked_loss(input int which);
    int k;
    @(negedge clk);
    m_al = (which == 0); m_ch = (which == 1); m_gl = (which == 2);
    sig = 1'b1;
    k = cyc + 1;
    expect_at(k + BITW + 1, 0, 1'b1, "R10");
    expect_at(k + BITW + 2, 1, 1'b1, "R10");
    expect_at(k + BITW + 2, 2, 1'b0, "R10");
    expect_at(k + BITW + 3, 2, 1'b0, "R10");
    drain();
    sig = 1'b0; m_al = 1'b0; m_ch = 1'b0; m_gl = 1'b0;
    repeat (4) @(negedge clk);
    clear_status();
  endtask

  initial begin
    int k;
    int j;
    int r;
    repeat (4) @(negedge clk);
    checks++;
    if (alarm !== 1'b0 || status !== 1'b0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: in reset actual=%0b%0b%0b expected=000", alarm, status, irq);
    end
    rst_n = 1'b1;
    expect_at(cyc + 1, 0, 1'b0, "R1");
    expect_at(cyc + 1, 1, 1'b0, "R1");
    expect_at(cyc + 1, 2, 1'b0, "R1");
    drain();

    // R3, R6, R9: bit-period window, no masks
    mode = 1'b1;
    @(negedge clk);
    sig = 1'b1;
    k = cyc + 1;
    expect_at(k + BITW,     0, 1'b0, "R3");
    expect_at(k + BITW + 1, 0, 1'b1, "R3");
    expect_at(k + BITW + 1, 1, 1'b0, "R6");
    expect_at(k + BITW + 2, 1, 1'b1, "R6");
    expect_at(k + BITW + 2, 2, 1'b1, "R9");
    expect_at(k + BITW + 3, 2, 1'b0, "R9");
    expect_at(k + BITW + 12, 0, 1'b1, "R5");
    expect_at(k + BITW + 12, 1, 1'b1, "R6");
    drain();

    // R5: flag drop
    sig = 1'b0;
    j = cyc + 1;
    expect_at(j + 1, 0, 1'b1, "R5");
    expect_at(j + 2, 0, 1'b0, "R5");
    expect_at(j + 2, 1, 1'b1, "R6");
    drain();

    // R7: read clears
    rd = 1'b1;
    r = cyc + 1;
    expect_at(r, 1, 1'b0, "R7");
    @(negedge clk);
    rd = 1'b0;
    expect_at(r + 3, 1, 1'b0, "R7");
    drain();

    // R4: short burst then a full window again
    sig = 1'b1;
    repeat (20) @(negedge clk);
    sig = 1'b0;
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 0, 1'b0, "R4");
    sig = 1'b1;
    k = cyc + 1;
    expect_at(k + BITW,     0, 1'b0, "R4");
    expect_at(k + BITW + 1, 0, 1'b1, "R4");
    drain();
    sig = 1'b0;
    repeat (4) @(negedge clk);
    clear_status();

    // R10: each mask alone blocks the pulse
    for (int m = 0; m < 3; m++) masked_loss(m);

    // R8: read coinciding with the rise
    @(negedge clk);
    sig = 1'b1;
    k = cyc + 1;
    while (cyc < k + BITW + 1) @(negedge clk);
    rd = 1'b1;
    expect_at(k + BITW + 2, 1, 1'b1, "R8");
    expect_at(k + BITW + 2, 2, 1'b1, "R9");
    @(negedge clk);
    rd = 1'b0;
    expect_at(k + BITW + 4, 1, 1'b1, "R8");
    drain();

    // R7: read while alarm still high
    rd = 1'b1;
    r = cyc + 1;
    expect_at(r, 0, 1'b1, "R7");
    expect_at(r, 1, 1'b0, "R7");
    @(negedge clk);
    rd = 1'b0;
    expect_at(r + 5, 0, 1'b1, "R7");
    expect_at(r + 5, 1, 1'b0, "R7");
    drain();
    sig = 1'b0;
    repeat (4) @(negedge clk);

    // R2: millisecond window
    mode = 1'b0;
    @(negedge clk);
    sig = 1'b1;
    k = cyc + 1;
    expect_at(k + MSW,     0, 1'b0, "R2");
    expect_at(k + MSW + 1, 0, 1'b1, "R2");
    expect_at(k + MSW + 2, 1, 1'b1, "R2");
    expect_at(k + MSW + 2, 2, 1'b1, "R2");
    drain();
    sig = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule